// File: doc/BRIEF.md
# Dataflow Operand Matcher with Direct Frame Slots

This block is the operand-matching and token-forming stage of a dataflow processing element. Each incoming token carries a data value and a continuation. The continuation is a frame base and an instruction address. A port bit marks the token as the left or right operand. The block fetches the instruction word at the token's instruction address. For a two-operand instruction, it checks the presence flag of one frame slot. The slot address is the frame base plus the slot offset from the instruction word.

When the first operand of a pair arrives, its value is parked in the slot and the flag is raised. When the partner arrives, the operation fires with the two values in left/right order. The flag is then cleared so the slot can be used again. Single-operand instructions fire at once and never touch the frame. Each firing produces one or two result tokens on a valid/ready output. A result token keeps the frame base and carries the instruction address plus a signed relative offset.

Top module: `ets_matcher`

## Requirements
- R1: After reset, `tok_ready` is 1, `out_valid` is 0, and every frame presence flag is clear.
- R2: Instruction word layout (IPW=6, OFFW=3):
  - bits [2:0]: opcode.
  - bit 3: two-destination flag.
  - bit 4: port of destination 0.
  - bit 5: port of destination 1.
  - bits [8:6]: slot offset.
  - bits [14:9]: destination 0 offset.
  - bits [20:15]: destination 1 offset.
  - Both destination offsets are two's complement, added modulo 2^IPW.
- R3: A two-operand token that finds its slot flag clear stores its value and sets the flag. It emits no output, and `tok_ready` returns two cycles after acceptance.
- R4: A two-operand token that finds its slot flag set fires the operation with the stored and incoming values and clears the flag. `out_valid` rises in the second cycle after acceptance.
- R5: Port bit 0 is the left operand and port bit 1 is the right operand. SUB yields left minus right, whichever operand arrives first.
- R6: Opcodes, modulo 2^DW:
  - 0 ADD, 1 SUB, 2 XOR, 3 AND (two operands).
  - 4 PASS, 5 INC (+1), 6 NEG (0−v), 7 NOT (bitwise) (one operand).
- R7: A one-operand instruction fires at once from the incoming value. It leaves every presence flag and stored value unchanged.
- R8: A result token carries the incoming frame base and the port bit of its destination. Its instruction address is the incoming address plus that destination's offset, modulo 2^IPW.
- R9: With the two-destination flag set, destination 0 is emitted first and destination 1 on the next accepted transfer. Otherwise only destination 0 is emitted.
- R10: While `out_valid` is 1 and `out_ready` is 0, all output fields hold their values.
- R11: Only one token is in flight at a time: `tok_ready` is 0 while a token is being looked up or emitted. The slot address is frame base plus slot offset, modulo 2^FPW.
- R12: A slot whose pair has fired can be reused by a new pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_we | input | 1 | Instruction store write enable |
| imem_addr | input | IPW | Instruction store write address |
| imem_wdata | input | 6+OFFW+2*IPW | Instruction word to write |
| tok_valid | input | 1 | Incoming token valid |
| tok_ready | output | 1 | Block can accept a token |
| tok_value | input | DW | Incoming operand value |
| tok_fp | input | FPW | Incoming frame base |
| tok_ip | input | IPW | Incoming instruction address |
| tok_port | input | 1 | Operand side: 0 left, 1 right |
| out_valid | output | 1 | Result token valid |
| out_ready | input | 1 | Consumer accepts result token |
| out_value | output | DW | Result value |
| out_fp | output | FPW | Result frame base |
| out_ip | output | IPW | Result instruction address |
| out_port | output | 1 | Result operand side |

## Verification
Some properties are checked by assertions on every cycle:
- Store, fire and one-operand events are mutually exclusive.
- A store is followed by a free input and no output.
- A firing is followed by a valid result.
- Input acceptance is blocked while a result is pending.
- Output fields stay stable under backpressure.

Other behaviour only the bench scenarios can show:
- The correct arithmetic for each opcode.
- Left/right ordering for both arrival orders.
- Relative destination arithmetic, including wraparound.
- Slot addresses that wrap around.
- Reuse of a slot after it fires.
- A one-operand instruction leaving a pending stored operand intact.

// File: rtl/ets_pkg.sv
package ets_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_XOR  = 3'd2,
    OP_AND  = 3'd3,
    OP_PASS = 3'd4,
    OP_INC  = 3'd5,
    OP_NEG  = 3'd6,
    OP_NOT  = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_LOOK, ST_EMIT0, ST_EMIT1
  } st_e;

  // opcode bit 2 clear means the instruction waits for two operands
  function automatic logic needs_pair(op_e op);
    return ~op[2];
  endfunction
endpackage

// File: rtl/ets_alu.sv
module ets_alu
  import ets_pkg::*;
#(
  parameter int DW = 16
) (
  input  op_e           op,
  input  logic [DW-1:0] lhs,
  input  logic [DW-1:0] rhs,
  output logic [DW-1:0] y
);
  always_comb begin
    unique case (op)
      OP_ADD:  y = lhs + rhs;
      OP_SUB:  y = lhs - rhs;
      OP_XOR:  y = lhs ^ rhs;
      OP_AND:  y = lhs & rhs;
      OP_PASS: y = lhs;
      OP_INC:  y = lhs + DW'(1);
      OP_NEG:  y = '0 - lhs;
      default: y = ~lhs;
    endcase
  end
endmodule

// File: rtl/ets_imem.sv
module ets_imem #(
  parameter int IW  = 21,
  parameter int IPW = 6
) (
  input  logic           clk,
  input  logic           we,
  input  logic [IPW-1:0] waddr,
  input  logic [IW-1:0]  wdata,
  input  logic [IPW-1:0] raddr,
  output logic [IW-1:0]  rdata
);
  localparam int DEPTH = 1 << IPW;
  logic [IW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/ets_frame.sv
module ets_frame #(
  parameter int DW  = 16,
  parameter int FAW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [FAW-1:0] addr,
  input  logic           set_en,
  input  logic           clr_en,
  input  logic [DW-1:0]  wval,
  output logic           present,
  output logic [DW-1:0]  rval
);
  localparam int DEPTH = 1 << FAW;
  logic [DEPTH-1:0] flag_q;
  logic [DW-1:0]    slot_q [DEPTH];

  // one access per cycle: read, and at most one of set/clear on that address
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else if (set_en) begin
      flag_q[addr] <= 1'b1;
    end else if (clr_en) begin
      flag_q[addr] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (set_en) slot_q[addr] <= wval;
  end

  assign present = flag_q[addr];
  assign rval    = slot_q[addr];
endmodule

// File: rtl/ets_matcher.sv
module ets_matcher
  import ets_pkg::*;
#(
  parameter int DW   = 16,
  parameter int FPW  = 6,
  parameter int IPW  = 6,
  parameter int OFFW = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    imem_we,
  input  logic [IPW-1:0]          imem_addr,
  input  logic [6+OFFW+2*IPW-1:0] imem_wdata,
  input  logic                    tok_valid,
  output logic                    tok_ready,
  input  logic [DW-1:0]           tok_value,
  input  logic [FPW-1:0]          tok_fp,
  input  logic [IPW-1:0]          tok_ip,
  input  logic                    tok_port,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [DW-1:0]           out_value,
  output logic [FPW-1:0]          out_fp,
  output logic [IPW-1:0]          out_ip,
  output logic                    out_port
);
  localparam int IW     = 6 + OFFW + 2 * IPW;
  localparam int OFF_LO = 6;
  localparam int D0_LO  = OFF_LO + OFFW;
  localparam int D1_LO  = D0_LO + IPW;

  st_e            st;
  logic [DW-1:0]  t_val, res_q;
  logic [FPW-1:0] t_fp;
  logic [IPW-1:0] t_ip, d0_q, d1_q;
  logic           t_port, two_q, p0_q, p1_q;

  logic [IW-1:0]   iw_cur;
  op_e             op_c;
  logic [OFFW-1:0] off_c;
  logic [FPW-1:0]  slot_addr;
  logic            pair_c, f_present;
  logic [DW-1:0]   f_val, alu_l, alu_r, alu_y;

  // named internal events, observed by the checker
  logic ev_store, ev_fire, ev_mono;

  ets_imem #(.IW(IW), .IPW(IPW)) u_imem (
    .clk(clk), .we(imem_we), .waddr(imem_addr), .wdata(imem_wdata),
    .raddr(t_ip), .rdata(iw_cur)
  );

  assign op_c      = op_e'(iw_cur[2:0]);
  assign off_c     = iw_cur[OFF_LO +: OFFW];
  assign pair_c    = needs_pair(op_c);
  assign slot_addr = t_fp + FPW'(off_c);

  assign ev_mono  = (st == ST_LOOK) && !pair_c;
  assign ev_store = (st == ST_LOOK) && pair_c && !f_present;
  assign ev_fire  = (st == ST_LOOK) && pair_c && f_present;

  ets_frame #(.DW(DW), .FAW(FPW)) u_frame (
    .clk(clk), .rst_n(rst_n), .addr(slot_addr),
    .set_en(ev_store), .clr_en(ev_fire), .wval(t_val),
    .present(f_present), .rval(f_val)
  );

  // incoming right operand means the parked one is the left
  always_comb begin
    if (ev_fire && t_port) begin
      alu_l = f_val;
      alu_r = t_val;
    end else begin
      alu_l = t_val;
      alu_r = f_val;
    end
  end

  ets_alu #(.DW(DW)) u_alu (.op(op_c), .lhs(alu_l), .rhs(alu_r), .y(alu_y));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE;
    end else begin
      unique case (st)
        ST_IDLE:  if (tok_valid) st <= ST_LOOK;
        ST_LOOK:  st <= ev_store ? ST_IDLE : ST_EMIT0;
        ST_EMIT0: if (out_ready) st <= two_q ? ST_EMIT1 : ST_IDLE;
        default:  if (out_ready) st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == ST_IDLE && tok_valid) begin
      t_val  <= tok_value;
      t_fp   <= tok_fp;
      t_ip   <= tok_ip;
      t_port <= tok_port;
    end
    if (st == ST_LOOK) begin
      res_q <= alu_y;
      two_q <= iw_cur[3];
      p0_q  <= iw_cur[4];
      p1_q  <= iw_cur[5];
      d0_q  <= iw_cur[D0_LO +: IPW];
      d1_q  <= iw_cur[D1_LO +: IPW];
    end
  end

  assign tok_ready = (st == ST_IDLE);
  assign out_valid = (st == ST_EMIT0) || (st == ST_EMIT1);
  assign out_value = res_q;
  assign out_fp    = t_fp;
  assign out_ip    = t_ip + ((st == ST_EMIT1) ? d1_q : d0_q);
  assign out_port  = (st == ST_EMIT1) ? p1_q : p0_q;
endmodule

// File: rtl/ets_matcher_chk.sv
module ets_matcher_chk #(
  parameter int DW  = 16,
  parameter int FPW = 6,
  parameter int IPW = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tok_ready,
  input logic           out_valid,
  input logic           out_ready,
  input logic [DW-1:0]  out_value,
  input logic [FPW-1:0] out_fp,
  input logic [IPW-1:0] out_ip,
  input logic           out_port,
  input logic           ev_store,
  input logic           ev_fire,
  input logic           ev_mono
);
  // R10
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_value) && $stable(out_fp)
                                   && $stable(out_ip) && $stable(out_port)));

  // R3
  store_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_store |=> (tok_ready && !out_valid));

  // R4
  fire_emits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fire |=> out_valid);

  // R7
  mono_emits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mono |=> out_valid);

  // R11
  single_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_store, ev_fire, ev_mono}));

  // R11
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || ev_fire || ev_mono || ev_store) |-> !tok_ready);
endmodule

bind ets_matcher ets_matcher_chk #(.DW(DW), .FPW(FPW), .IPW(IPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tok_ready(tok_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_value(out_value), .out_fp(out_fp), .out_ip(out_ip),
  .out_port(out_port), .ev_store(ev_store), .ev_fire(ev_fire), .ev_mono(ev_mono)
);

// File: tb/tb_ets_matcher.sv
module tb_ets_matcher;
  localparam int DW = 16, FPW = 6, IPW = 6, OFFW = 3;
  localparam int IW = 6 + OFFW + 2 * IPW;

  typedef struct packed {
    logic [DW-1:0]  val;
    logic [FPW-1:0] fp;
    logic [IPW-1:0] ip;
    logic           port;
  } tok_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic imem_we = 1'b0;
  logic [IPW-1:0] imem_addr = '0;
  logic [IW-1:0]  imem_wdata = '0;
  logic tok_valid = 1'b0, tok_port = 1'b0, out_ready = 1'b1;
  logic [DW-1:0] tok_value = '0;
  logic [FPW-1:0] tok_fp = '0;
  logic [IPW-1:0] tok_ip = '0;
  logic tok_ready, out_valid, out_port;
  logic [DW-1:0] out_value;
  logic [FPW-1:0] out_fp;
  logic [IPW-1:0] out_ip;

  int nvec = 0, nbad = 0;
  bit done = 0;
  tok_t expq[$];
  string tagq[$];

  always #10 clk = ~clk;

  ets_matcher #(.DW(DW), .FPW(FPW), .IPW(IPW), .OFFW(OFFW)) dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every accepted result token
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      tok_t got;
      got = '{val: out_value, fp: out_fp, ip: out_ip, port: out_port};
      if (expq.size() == 0) begin
        chk(0, "R3", "unexpected result token", got, 0);
      end else begin
        tok_t e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        chk(got == e, t, "result token", got, e);
      end
    end
  end

  function automatic logic [DW-1:0] model(input int op, input logic [DW-1:0] l,
                                          input logic [DW-1:0] r);
    if (op == 0) return l + r;
    if (op == 1) return l + ~r + 1'b1;
    if (op == 2) return (l | r) & ~(l & r);
    if (op == 3) return ~(~l | ~r);
    if (op == 4) return l;
    if (op == 5) return l + 1'b1;
    if (op == 6) return ~l + 1'b1;
    return l ^ {DW{1'b1}};
  endfunction

  function automatic logic [IW-1:0] word(input int op, input bit two, input bit p0,
                                         input bit p1, input int off, input int d0,
                                         input int d1);
    return {IPW'(d1), IPW'(d0), OFFW'(off), p1, p0, two, 3'(op)};
  endfunction

  task automatic put(input int a, input logic [IW-1:0] w);
    @(negedge clk);
    imem_we = 1; imem_addr = IPW'(a); imem_wdata = w;
    @(negedge clk);
    imem_we = 0;
  endtask

  task automatic send(input logic [DW-1:0] v, input int fp, input int ip, input bit p);
    @(negedge clk);
    tok_valid = 1; tok_value = v; tok_fp = FPW'(fp); tok_ip = IPW'(ip); tok_port = p;
    while (!tok_ready) @(negedge clk);
    @(negedge clk);
    tok_valid = 0;
  endtask

  task automatic expect_tok(input logic [DW-1:0] v, input int fp, input int ip,
                            input bit p, input string req);
    expq.push_back('{val: v, fp: FPW'(fp), ip: IPW'(ip), port: p});
    tagq.push_back(req);
  endtask

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(tok_ready == 1, "R1", "tok_ready after reset", tok_ready, 1);
    chk(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);

    // R2 program layout: op, two, p0, p1, off, d0, d1
    put(0,  word(0, 1, 0, 1, 1, 3, -1));
    put(1,  word(1, 0, 1, 0, 2, 1, 0));
    put(2,  word(5, 1, 0, 1, 2, 5, 10));
    put(3,  word(2, 0, 0, 0, 3, 0, 0));
    put(4,  word(3, 0, 1, 0, 4, 60, 0));
    put(5,  word(4, 0, 0, 0, 0, -5, 0));
    put(6,  word(6, 0, 1, 0, 0, 1, 0));
    put(7,  word(7, 0, 0, 0, 0, 1, 0));
    put(62, word(0, 0, 0, 0, 7, 3, 0));

    // R3 first operand parks quietly (flags clear from R1)
    send(16'd7, 10, 0, 0);
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R3", "no output after first operand", out_valid, 0);
    chk(tok_ready == 1, "R3", "ready after store", tok_ready, 1);
    // R4 R8 R9 partner fires, two destinations in order
    expect_tok(model(0, 7, 5), 10, 3, 0, "R9");
    expect_tok(model(0, 7, 5), 10, 63, 1, "R8");
    send(16'd5, 10, 0, 1);
    drain();

    // R5 SUB with right first, then left first
    expect_tok(model(1, 10, 3), 20, 2, 1, "R5");
    send(16'd3, 20, 1, 1);
    send(16'd10, 20, 1, 0);
    drain();
    expect_tok(model(1, 3, 10), 21, 2, 1, "R5");
    send(16'd3, 21, 1, 0);
    send(16'd10, 21, 1, 1);
    drain();

    // R7 one-operand instruction on same slot leaves parked operand alone
    send(16'd100, 30, 1, 0);
    expect_tok(model(5, 41, 0), 30, 7, 0, "R7");
    expect_tok(model(5, 41, 0), 30, 12, 1, "R7");
    send(16'd41, 30, 2, 0);
    drain();
    expect_tok(model(1, 100, 1), 30, 2, 1, "R7");
    send(16'd1, 30, 1, 1);
    drain();

    // R12 reuse of the slot from the first pair
    expect_tok(model(0, 1, 2), 10, 3, 0, "R12");
    expect_tok(model(0, 1, 2), 10, 63, 1, "R12");
    send(16'd1, 10, 0, 0);
    send(16'd2, 10, 0, 1);
    drain();

    // R6 remaining opcodes
    expect_tok(model(2, 16'hF0F0, 16'h0FF3), 40, 3, 0, "R6");
    send(16'hF0F0, 40, 3, 0);
    send(16'h0FF3, 40, 3, 1);
    expect_tok(model(3, 16'hABCD, 16'h0FF0), 41, 0, 1, "R6");
    send(16'hABCD, 41, 4, 1);
    send(16'h0FF0, 41, 4, 0);
    expect_tok(model(4, 16'h1234, 0), 42, 0, 0, "R6");
    send(16'h1234, 42, 5, 1);
    expect_tok(model(6, 16'h0005, 0), 43, 7, 1, "R6");
    send(16'h0005, 43, 6, 0);
    expect_tok(model(7, 16'h00FF, 0), 44, 8, 0, "R6");
    send(16'h00FF, 44, 7, 0);
    drain();

    // R11 slot address and R8 destination both wrap
    expect_tok(model(0, 16'hFFFF, 16'd2), 62, 1, 0, "R11");
    send(16'hFFFF, 62, 62, 0);
    send(16'd2, 62, 62, 1);
    drain();

    // R10 backpressure holds the token, R11 no new acceptance
    out_ready = 0;
    expect_tok(16'h0055, 3, 0, 0, "R10");
    send(16'h0055, 3, 5, 0);
    repeat (4) @(negedge clk);
    chk(out_valid == 1, "R10", "valid held under stall", out_valid, 1);
    chk(out_value == 16'h0055, "R10", "value held under stall", out_value, 16'h0055);
    chk(tok_ready == 0, "R11", "input blocked while busy", tok_ready, 0);
    out_ready = 1;
    drain();
    chk(expq.size() == 0, "R9", "scoreboard empty", expq.size(), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nvec++;
      nbad++;
      $display("FAIL R11 watchdog expired: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule